// File: doc/BRIEF.md
# Multi-cause reset pulse sequencer

This block turns several reset causes into one stretched, active-low external reset pulse. It also drives four internal domain resets and a flag that says when a slower downstream peripheral may be accessed. The causes are a synchronised external request, which a select input marks as master or normal; a single-cycle soft-reset strobe; and a watchdog with a programmable timeout that software must service. The length of the pulse depends on the cause. A soft pulse is short and a full pulse is long. Each cause also leaves a different set of internal domains untouched. Once the pulse ends, a settle counter holds the ready flag low until the peripheral has had time to come out of reset.

The control is one state machine with three states. **PULSE** drives the reset outputs. **SETTLE** counts the hold-off. **READY** means that access is allowed. The transitions are:

- *restart* (PULSE to PULSE): a new request arrives.
- *pulse done* (PULSE to SETTLE): the pulse counter reaches the active length.
- *settle done* (SETTLE to READY): the hold-off counter reaches its limit.
- *new reset* (SETTLE or READY to PULSE): any request arrives.

A cause register records which cause started the pulse, and it can still be read after the pulse has ended. The block's own reset input puts it into PULSE as a master reset.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_n` is low, all reset outputs are low, `dev_ready` is low and `last_cause` is 3 (master). After release, a pulse of LONG_LEN cycles follows, so `dev_ready` first reads high LONG_LEN+SETTLE_LEN cycles after release.
- R2: A `soft_req` strobe sampled outside a pulse holds `ext_rst_n` low for exactly SOFT_LEN cycles (default 128), starting in the cycle after the sampling edge.
- R3: A normal or master external request, or a watchdog timeout, holds `ext_rst_n` low for LONG_LEN cycles (default 32768), counted from the last edge at which the request was seen.
- R4: `ext_req_n` passes through two synchroniser flops. A low level at one edge reaches the pins three cycles after it is driven. While the level stays low, every sampled cycle restarts the pulse. `ext_kind` = 1 selects master and 0 selects normal.
- R5: During a pulse the domain pins go low according to the cause. Soft reset asserts `core_rst_n` and `per_rst_n`. Normal reset and watchdog reset also assert `plat_rst_n`. Master reset also asserts `mem_rst_n`. Outside a pulse, all domain pins are high.
- R6: A `wdt_limit` of 0 disables the watchdog. Otherwise its count is cleared during a pulse, by a `wdt_kick` or while it is disabled, and it advances once per cycle. It fires when the count reaches `wdt_limit` with no kick in that cycle, so the pulse starts `wdt_limit`+2 cycles after the cycle in which the last kick was driven.
- R7: `dev_ready` is low during a pulse and for SETTLE_LEN cycles (default 1100) after `ext_rst_n` rises. It stays high after that until the next request.
- R8: A request during a pulse restarts the pulse count from zero. The new length is the longer of the running length and the requested one, and the domain set becomes the union of both. A pulse is never shortened.
- R9: `last_cause` encodes soft=0, normal=1, watchdog=2, master=3. It is loaded when a pulse starts. A restart keeps the larger code. When requests arrive in the same cycle, the largest code wins. The value is held after the pulse ends.
- R10: Every pulse lasts at least SOFT_LEN cycles. The default SOFT_LEN of 128 is well above the peripheral's minimum of about 14 host clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block (power-on) |
| ext_req_n | input | 1 | Asynchronous active-low external reset request |
| ext_kind | input | 1 | Cause of the external request: 1 is master, 0 is normal |
| soft_req | input | 1 | Single-cycle soft-reset strobe |
| wdt_kick | input | 1 | Watchdog service strobe |
| wdt_limit | input | 16 | Watchdog timeout in cycles; 0 disables the watchdog |
| ext_rst_n | output | 1 | Stretched external reset pin, active low |
| core_rst_n | output | 1 | Core domain reset, active low |
| per_rst_n | output | 1 | Ordinary peripheral domain reset, active low |
| plat_rst_n | output | 1 | Platform domain reset (system integration, chip select, interrupt controller, GPIO), active low |
| mem_rst_n | output | 1 | Memory controller domain reset, active low |
| dev_ready | output | 1 | High once the downstream settle time has elapsed |
| last_cause | output | 2 | Cause of the most recent pulse |

## Verification
The assertions take `ext_kind` to be stable whenever `ext_req_n` is low or a request is still inside the synchroniser. They also take `wdt_limit` to change only during a pulse or while the watchdog count is still zero. The bench therefore sets the select before it lowers the request and holds it until the pulse has started. It changes the limit only when the watchdog is disabled or while the pin is low. Every soft strobe and every external request lasts a whole number of cycles. Inputs are driven on the falling clock edge, so the synchroniser never sees a level that changes at its sampling edge.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Cause codes; the numeric order is the priority order.
    typedef enum logic [1:0] {
        CAUSE_SOFT   = 2'd0,
        CAUSE_NORMAL = 2'd1,
        CAUSE_WDOG   = 2'd2,
        CAUSE_MASTER = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_PULSE  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_READY  = 2'd2
    } seq_state_e;

    // Set bit = domain is held in reset during the pulse.
    typedef struct packed {
        logic mem;
        logic plat;
        logic per;
        logic core;
    } dom_t;

    function automatic dom_t dom_of(cause_e c);
        dom_t d;
        d.core = 1'b1;
        d.per  = 1'b1;
        d.plat = (c != CAUSE_SOFT);
        d.mem  = (c == CAUSE_MASTER);
        return d;
    endfunction

    function automatic logic is_long(cause_e c);
        return c != CAUSE_SOFT;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= IDLE;
                    else        pipe[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[i] <= IDLE;
                    else        pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rstseq_wdog.sv
module rstseq_wdog #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         kick,
    input  logic [W-1:0] limit,
    output logic         fire
);
    logic [W-1:0] cnt;
    logic         enabled;

    assign enabled = (limit != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt <= '0;
        else if (hold || kick || !enabled)   cnt <= '0;
        else if (cnt != {W{1'b1}})           cnt <= cnt + W'(1);
    end

    assign fire = !hold && !kick && enabled && (cnt >= limit);

    AST_WDOG_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n) fire |=> !fire); // R6
    AST_WDOG_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) kick |=> !fire); // R6
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int SOFT_LEN   = 128,
    parameter int LONG_LEN   = 32768,
    parameter int SETTLE_LEN = 1100
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_vld,
    input  cause_e req_cause,
    output logic   in_pulse,
    output logic   dev_ready,
    output dom_t   dom_act,
    output cause_e cause_q
);
    localparam int CNT_W = $clog2(LONG_LEN + 1);
    localparam int SET_W = $clog2(SETTLE_LEN + 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);
    localparam logic [CNT_W-1:0] SOFT_LAST  = CNT_W'(SOFT_LEN - 1);
    localparam logic [SET_W-1:0] SETTLE_LAST = SET_W'(SETTLE_LEN - 1);

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SET_W-1:0] scnt_q, scnt_d;
    logic             long_q, long_d;
    dom_t             dom_q, dom_d;
    cause_e           cause_d;
    logic [CNT_W-1:0] pulse_last;

    assign pulse_last = long_q ? LONG_LAST : SOFT_LAST;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_PULSE;
            cnt_q   <= '0;
            scnt_q  <= '0;
            long_q  <= 1'b1;
            dom_q   <= '1;
            cause_q <= CAUSE_MASTER;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            scnt_q  <= scnt_d;
            long_q  <= long_d;
            dom_q   <= dom_d;
            cause_q <= cause_d;
        end
    end

    // Next state
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        scnt_d  = scnt_q;
        long_d  = long_q;
        dom_d   = dom_q;
        cause_d = cause_q;
        unique case (st_q)
            ST_PULSE: begin
                if (req_vld) begin                       // restart
                    cnt_d   = '0;
                    long_d  = long_q | is_long(req_cause);
                    dom_d   = dom_t'(dom_q | dom_of(req_cause));
                    cause_d = (req_cause > cause_q) ? req_cause : cause_q;
                end else if (cnt_q == pulse_last) begin  // pulse done
                    st_d   = ST_SETTLE;
                    scnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_SETTLE: begin
                if (req_vld) begin                       // new reset
                    st_d    = ST_PULSE;
                    cnt_d   = '0;
                    long_d  = is_long(req_cause);
                    dom_d   = dom_of(req_cause);
                    cause_d = req_cause;
                end else if (scnt_q == SETTLE_LAST) begin // settle done
                    st_d = ST_READY;
                end else begin
                    scnt_d = scnt_q + SET_W'(1);
                end
            end
            ST_READY: begin
                if (req_vld) begin                       // new reset
                    st_d    = ST_PULSE;
                    cnt_d   = '0;
                    long_d  = is_long(req_cause);
                    dom_d   = dom_of(req_cause);
                    cause_d = req_cause;
                end
            end
            default: st_d = ST_PULSE;
        endcase
    end

    // Outputs
    always_comb begin
        in_pulse  = (st_q == ST_PULSE);
        dev_ready = (st_q == ST_READY);
        dom_act   = in_pulse ? dom_q : '0;
    end

    // Checker-side run length of the current pulse
    logic [CNT_W:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 low_run <= '0;
        else if (!in_pulse)         low_run <= '0;
        else if (low_run != '1)     low_run <= low_run + (CNT_W+1)'(1);
    end

    AST_PULSE_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(in_pulse) |-> (low_run >= (CNT_W+1)'(SOFT_LEN))); // R10
    AST_LONG_NOT_SHORTENED: assert property (@(posedge clk) disable iff (!rst_n) (in_pulse && long_q) |=> long_q); // R8
    AST_READY_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(dev_ready) |-> ($past(scnt_q) == SETTLE_LAST)); // R7
    AST_SOFT_SPARES_DOMAINS: assert property (@(posedge clk) disable iff (!rst_n) (in_pulse && cause_q == CAUSE_SOFT) |-> (!dom_act.plat && !dom_act.mem)); // R5
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int SOFT_LEN    = 128,
    parameter int LONG_LEN    = 32768,
    parameter int SETTLE_LEN  = 1100,
    parameter int WDT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_req_n,
    input  logic             ext_kind,
    input  logic             soft_req,
    input  logic             wdt_kick,
    input  logic [WDT_W-1:0] wdt_limit,
    output logic             ext_rst_n,
    output logic             core_rst_n,
    output logic             per_rst_n,
    output logic             plat_rst_n,
    output logic             mem_rst_n,
    output logic             dev_ready,
    output logic [1:0]       last_cause
);
    logic   ext_sync_n;
    logic   wdt_fire;
    logic   in_pulse;
    logic   req_vld;
    cause_e req_cause;
    cause_e cause_q;
    dom_t   dom_act;

    rstseq_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_req_n), .q(ext_sync_n)
    );

    rstseq_wdog #(.W(WDT_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .hold(in_pulse), .kick(wdt_kick),
        .limit(wdt_limit), .fire(wdt_fire)
    );

    // Request merge: later lines win, ascending cause code.
    always_comb begin
        req_vld   = 1'b0;
        req_cause = CAUSE_SOFT;
        if (soft_req) begin
            req_vld = 1'b1; req_cause = CAUSE_SOFT;
        end
        if (!ext_sync_n && !ext_kind) begin
            req_vld = 1'b1; req_cause = CAUSE_NORMAL;
        end
        if (wdt_fire) begin
            req_vld = 1'b1; req_cause = CAUSE_WDOG;
        end
        if (!ext_sync_n && ext_kind) begin
            req_vld = 1'b1; req_cause = CAUSE_MASTER;
        end
    end

    rstseq_ctrl #(.SOFT_LEN(SOFT_LEN), .LONG_LEN(LONG_LEN), .SETTLE_LEN(SETTLE_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_cause(req_cause),
        .in_pulse(in_pulse), .dev_ready(dev_ready), .dom_act(dom_act), .cause_q(cause_q)
    );

    assign ext_rst_n  = !in_pulse;
    assign core_rst_n = !dom_act.core;
    assign per_rst_n  = !dom_act.per;
    assign plat_rst_n = !dom_act.plat;
    assign mem_rst_n  = !dom_act.mem;
    assign last_cause = cause_q;

    AST_MEM_IMPLIES_PLAT: assert property (@(posedge clk) disable iff (!rst_n) !mem_rst_n |-> !plat_rst_n); // R5
    AST_DOMAIN_INSIDE_PIN: assert property (@(posedge clk) disable iff (!rst_n) !per_rst_n |-> (!ext_rst_n && !core_rst_n)); // R5
    AST_READY_NOT_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !ext_rst_n |=> !dev_ready); // R7
endmodule

// File: tb/rstseq_top_test.sv
module rstseq_top_test;
    localparam int SOFT   = 12;
    localparam int LONG   = 48;
    localparam int SETTLE = 30;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ext_req_n, ext_kind, soft_req, wdt_kick;
    logic [15:0] wdt_limit;
    logic        ext_rst_n, core_rst_n, per_rst_n, plat_rst_n, mem_rst_n, dev_ready;
    logic [1:0]  last_cause;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    rstseq_top #(.SOFT_LEN(SOFT), .LONG_LEN(LONG), .SETTLE_LEN(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .ext_kind(ext_kind),
        .soft_req(soft_req), .wdt_kick(wdt_kick), .wdt_limit(wdt_limit),
        .ext_rst_n(ext_rst_n), .core_rst_n(core_rst_n), .per_rst_n(per_rst_n),
        .plat_rst_n(plat_rst_n), .mem_rst_n(mem_rst_n), .dev_ready(dev_ready),
        .last_cause(last_cause)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // phase: 0 pulse, 1 settle, 2 ready
    int m_phase = 0, m_cnt = 0, m_sc = 0, m_cause = 3, m_dom = 15, m_w = 0;
    bit m_long = 1, m_s1 = 1, m_s2 = 1;
    int rq_code;
    bit rq_any, m_fire;

    function automatic int doms(input int c);
        return 3 | ((c != 0) ? 4 : 0) | ((c == 3) ? 8 : 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_sc = 0; m_cause = 3; m_dom = 15;
            m_w = 0; m_long = 1; m_s1 = 1; m_s2 = 1;
        end else begin
            m_fire = (m_phase != 0) && (wdt_limit != 0) && !wdt_kick && (m_w >= int'(wdt_limit));
            rq_any = 0; rq_code = 0;
            if (soft_req) begin rq_any = 1; rq_code = 0; end
            if (!m_s2 && !ext_kind) begin rq_any = 1; rq_code = 1; end
            if (m_fire) begin rq_any = 1; rq_code = 2; end
            if (!m_s2 && ext_kind) begin rq_any = 1; rq_code = 3; end
            if (m_phase == 0 || wdt_kick || wdt_limit == 0) m_w = 0;
            else if (m_w < 65535) m_w++;
            if (m_phase == 0) begin
                if (rq_any) begin
                    m_cnt = 0;
                    if (rq_code != 0) m_long = 1;
                    m_dom = m_dom | doms(rq_code);
                    if (rq_code > m_cause) m_cause = rq_code;
                end else if (m_cnt == (m_long ? LONG : SOFT) - 1) begin
                    m_phase = 1; m_sc = 0;
                end else m_cnt++;
            end else if (rq_any) begin
                m_phase = 0; m_cnt = 0; m_long = (rq_code != 0);
                m_dom = doms(rq_code); m_cause = rq_code;
            end else if (m_phase == 1) begin
                if (m_sc == SETTLE - 1) m_phase = 2; else m_sc++;
            end
            m_s2 = m_s1; m_s1 = ext_req_n;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            int exp_pins;
            exp_pins = 15;
            if (m_phase == 0) exp_pins = 15 & ~m_dom;
            chk(ext_rst_n == (m_phase != 0), "R3 ext_rst_n vs model", ext_rst_n, m_phase != 0);
            chk({mem_rst_n, plat_rst_n, per_rst_n, core_rst_n} == exp_pins[3:0], "R5 domain pins vs model",
                {mem_rst_n, plat_rst_n, per_rst_n, core_rst_n}, exp_pins);
            chk(dev_ready == (m_phase == 2), "R7 dev_ready vs model", dev_ready, m_phase == 2);
            chk(last_cause == m_cause[1:0], "R9 last_cause vs model", last_cause, m_cause);
        end
    end

    // ---------------- directed helpers ----------------
    task automatic meas_low(output int n);
        int g = 0;
        n = 0;
        while (ext_rst_n && g < 5000) begin @(negedge clk); g++; end
        while (!ext_rst_n && n < 100000) begin n++; @(negedge clk); end
    endtask

    task automatic wait_ready();
        int g = 0;
        while (!dev_ready && g < 5000) begin @(negedge clk); g++; end
        chk(dev_ready, "R7 ready reached", dev_ready, 1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #800000;
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int n, lat, c, lows;
        rst_n = 1'b0; ext_req_n = 1'b1; ext_kind = 1'b0; soft_req = 1'b0;
        wdt_kick = 1'b0; wdt_limit = 16'd0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({ext_rst_n, mem_rst_n, plat_rst_n, per_rst_n, core_rst_n} == 5'b0, "R1 pins during reset",
            {ext_rst_n, mem_rst_n, plat_rst_n, per_rst_n, core_rst_n}, 0);
        chk(!dev_ready, "R1 ready during reset", dev_ready, 0);
        chk(last_cause == 2'd3, "R1 cause during reset", last_cause, 3);
        rst_n = 1'b1;
        c = 0;
        while (!dev_ready && c < 5000) begin @(negedge clk); c++; end
        chk(c == LONG + SETTLE, "R1 power-up pulse plus settle", c, LONG + SETTLE);

        // R2 soft pulse
        soft_req = 1'b1; @(negedge clk); soft_req = 1'b0;
        chk({mem_rst_n, plat_rst_n, per_rst_n, core_rst_n} == 4'b1100, "R5 soft domains",
            {mem_rst_n, plat_rst_n, per_rst_n, core_rst_n}, 4'b1100);
        meas_low(n);
        chk(n == SOFT, "R2 soft pulse length", n, SOFT);
        chk(n >= SOFT, "R10 minimum pulse length", n, SOFT);
        chk(last_cause == 2'd0, "R9 soft cause held", last_cause, 0);
        wait_ready();

        // R4 latency, R3 length, normal
        ext_kind = 1'b0; ext_req_n = 1'b0; lat = 0;
        do begin @(negedge clk); lat++; if (lat == 1) ext_req_n = 1'b1; end while (ext_rst_n && lat < 20);
        chk(lat == 3, "R4 synchroniser latency", lat, 3);
        chk({mem_rst_n, plat_rst_n, per_rst_n, core_rst_n} == 4'b1000, "R5 normal domains",
            {mem_rst_n, plat_rst_n, per_rst_n, core_rst_n}, 4'b1000);
        meas_low(n);
        chk(n == LONG, "R3 normal pulse length", n, LONG);
        chk(last_cause == 2'd1, "R9 normal cause", last_cause, 1);
        wait_ready();

        // R4 held master request: 5 low samples, measured from release -> LONG+2
        ext_kind = 1'b1; ext_req_n = 1'b0;
        repeat (5) @(negedge clk);
        ext_req_n = 1'b1;
        chk({mem_rst_n, plat_rst_n, per_rst_n, core_rst_n} == 4'b0000, "R5 master domains",
            {mem_rst_n, plat_rst_n, per_rst_n, core_rst_n}, 0);
        meas_low(n);
        chk(n == LONG + 2, "R4 held request restarts", n, LONG + 2);
        chk(last_cause == 2'd3, "R9 master cause", last_cause, 3);
        ext_kind = 1'b0;
        wait_ready();

        // R6 watchdog: serviced, then starved
        wdt_limit = 16'd20; lows = 0;
        for (int k = 0; k < 100; k++) begin
            wdt_kick = (k % 10 == 0);
            @(negedge clk);
            if (!ext_rst_n) lows++;
        end
        chk(lows == 0, "R6 serviced watchdog stays quiet", lows, 0);
        wdt_kick = 1'b1; @(negedge clk); wdt_kick = 1'b0; lat = 1;
        while (ext_rst_n && lat < 200) begin @(negedge clk); lat++; end
        chk(lat == 22, "R6 timeout latency", lat, 22);
        wdt_limit = 16'd0;
        meas_low(n);
        chk(n == LONG, "R3 watchdog pulse length", n, LONG);
        chk(last_cause == 2'd2, "R9 watchdog cause", last_cause, 2);
        wait_ready();
        lows = 0;
        for (int k = 0; k < 200; k++) begin @(negedge clk); if (!ext_rst_n) lows++; end
        chk(lows == 0, "R6 limit 0 disables watchdog", lows, 0);

        // R8 soft escalated by normal: LONG+2 from measurement start
        soft_req = 1'b1; @(negedge clk); soft_req = 1'b0;
        @(negedge clk); ext_req_n = 1'b0;
        @(negedge clk); ext_req_n = 1'b1;
        meas_low(n);
        chk(n == LONG + 2, "R8 escalation to long pulse", n, LONG + 2);
        chk(last_cause == 2'd1, "R9 escalated cause", last_cause, 1);
        wait_ready();

        // R8 soft inside a long pulse restarts the long count
        ext_req_n = 1'b0; @(negedge clk); ext_req_n = 1'b1;
        while (ext_rst_n) @(negedge clk);
        repeat (10) @(negedge clk);
        soft_req = 1'b1; @(negedge clk); soft_req = 1'b0;
        chk(plat_rst_n == 1'b0 && mem_rst_n == 1'b1, "R8 domain union kept", {mem_rst_n, plat_rst_n}, 2'b10);
        meas_low(n);
        chk(n == LONG, "R8 no shortening by soft", n, LONG);
        chk(last_cause == 2'd1, "R9 higher code kept", last_cause, 1);

        // R7 request during settle
        repeat (5) @(negedge clk);
        chk(!dev_ready, "R7 not ready during settle", dev_ready, 0);
        soft_req = 1'b1; @(negedge clk); soft_req = 1'b0;
        meas_low(n);
        chk(n == SOFT, "R2 soft from settle", n, SOFT);
        wait_ready();

        // R9 simultaneous soft and master
        soft_req = 1'b1; ext_kind = 1'b1; ext_req_n = 1'b0;
        @(negedge clk); soft_req = 1'b0; ext_req_n = 1'b1;
        meas_low(n);
        chk(last_cause == 2'd3, "R9 master wins over soft", last_cause, 3);
        chk(n >= LONG, "R8 merged pulse not short", n, LONG);
        ext_kind = 1'b0;
        wait_ready();

        finish_run();
    end
endmodule